// File: doc/BRIEF.md
# Redundant Pipeline Stage Code Combiner

This block sits behind a multistage pipelined analog-to-digital converter. The front stage makes a seven-level decision with a residue gain of four. A configurable number of middle stages follow, each making a three-level decision with a residue gain of two. A final 2-bit flash has no redundancy. Each stage settles its decision for a sample one clock after the stage in front of it. The combiner collects these skewed codes and delays each lane so that all codes of one sample meet. It then adds them with weights that overlap by one bit position, so that small comparator errors in any redundant stage cancel out in the final word.

The output is an offset-binary word. Its midpoint is 2^(W-1), where W = NMID + 4. A total that lands past the top of the range is clamped to all ones. A total that lands below zero is clamped to all zeros. The block also drives the three ternary controls of the front stage's multiplying DAC, encoded as separate positive and negative select vectors. Comparators, residue amplification and weight calibration are handled elsewhere.

Top module: `pipe_code_combiner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `out_word`, `dac_pos` and `dac_neg` are all zero.
- R2: A sample is presented in three parts. With `in_valid` high at clock edge t, `in_first` is taken at edge t. The code of middle stage k (k = 1..NMID, carried on `in_mid[2k-1:2k-2]`) is taken at edge t+k. `in_last` is taken at edge t+NMID+1. The corrected word for that sample appears with `out_valid` high for exactly one cycle, following edge t+NMID+2. Lane values at edges that belong to no sample have no effect.
- R3: The word is 2^(W-1) + (b0-3)·2^(NMID+1) + Σ(bk-1)·2^(NMID+1-k) + (f-1). Here b0 is the front code (0..6), bk is middle stage k's code (0..2) and f is the flash code (0..3).
- R4: A sum above 2^W-1 gives all ones. For example, all stages at their top code give all ones. A sum below 0 gives all zeros.
- R5: A front code of 7 is treated as 6 and a middle code of 3 is treated as 2, both in the sum and in the DAC controls.
- R6: One edge after each `in_first` value, the DAC controls reflect d = b0-3. Bit i of `dac_pos`/`dac_neg` carries control c(i+1), where +1 is pos=1, neg=0; -1 is pos=0, neg=1; and 0 is both low. c1 is +1 for d=3, 0 for d=2 and -1 otherwise. c2 is +1 for d≥1, 0 for d=0 and -1 otherwise. c3 is +1 for d≥-1, 0 for d=-2 and -1 for d=-3. The three controls always sum to d.
- R7: `out_word` keeps its last value while `out_valid` is low.
- R8: Samples started on consecutive edges produce outputs on consecutive cycles, each with its own word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the edge at which a sample's front code is taken |
| in_first | input | 3 | Seven-level front-stage decision |
| in_mid | input | 2*NMID | Three-level middle-stage decisions, stage 1 in the low bits |
| in_last | input | 2 | Final flash code |
| dac_pos | output | 3 | Positive selects of the front-stage DAC controls |
| dac_neg | output | 3 | Negative selects of the front-stage DAC controls |
| out_valid | output | 1 | Corrected word strobe |
| out_word | output | NMID+4 | Corrected offset-binary word |

## Verification
The stimulus mixes several kinds of samples: isolated samples, back-to-back bursts, all-top and all-bottom codes, the exact midscale pattern, and the out-of-range codes 7 and 3. Random junk is placed on every lane in cycles that carry no sample. A wrong skew depth therefore shows up as a wrong word, not as a silent match. The all-top pattern separates clamping from wrap-around, and the midscale pattern exposes offset errors. Front codes swept over all eight values on every cycle check each DAC control against its table entry.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

   localparam int FIRST_W = 3;
   localparam int MID_W   = 2;
   localparam int LAST_W  = 2;
   localparam int CTL_N   = 3;

   typedef struct packed {
      logic [CTL_N-1:0] pos;
      logic [CTL_N-1:0] neg;
   } tri_ctl_t;

   function automatic logic [FIRST_W-1:0] fold_first(input logic [FIRST_W-1:0] c);
      return (c == 3'd7) ? 3'd6 : c;
   endfunction

   function automatic logic [MID_W-1:0] fold_mid(input logic [MID_W-1:0] c);
      return (c == 2'd3) ? 2'd2 : c;
   endfunction

   // split a seven-level decision into three ternary selects (level = d + 3)
   function automatic tri_ctl_t split_first(input logic [FIRST_W-1:0] c);
      tri_ctl_t r;
      logic [FIRST_W-1:0] lv;
      lv       = fold_first(c);
      r.pos[0] = (lv == 3'd6);
      r.neg[0] = (lv <= 3'd4);
      r.pos[1] = (lv >= 3'd4);
      r.neg[1] = (lv <= 3'd2);
      r.pos[2] = (lv >= 3'd2);
      r.neg[2] = (lv == 3'd0);
      return r;
   endfunction

endpackage

// File: rtl/pcc_delay_line.sv
module pcc_delay_line #(
   parameter int WIDTH = 1,
   parameter int DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("pcc_delay_line: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r_q <= '0;
         else        r_q <= d;
      end
      assign q = r_q;
   end else begin : g_chain
      logic [DEPTH-1:0][WIDTH-1:0] taps;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            taps <= '0;
         end else begin
            taps[0] <= d;
            for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
         end
      end
      assign q = taps[DEPTH-1];
   end

endmodule

// File: rtl/pcc_dac_split.sv
module pcc_dac_split
   import pcc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIRST_W-1:0] code,
   output logic [CTL_N-1:0]   pos,
   output logic [CTL_N-1:0]   neg
);

   tri_ctl_t nxt, cur;

   always_comb nxt = split_first(code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= '0;
      else        cur <= nxt;
   end

   assign pos = cur.pos;
   assign neg = cur.neg;

endmodule

// File: rtl/pcc_code_sum.sv
module pcc_code_sum
   import pcc_pkg::*;
#(
   parameter int NMID   = 4,
   parameter bit SAT_EN = 1'b1,
   localparam int OUT_W = NMID + 4
) (
   input  logic [FIRST_W-1:0]    first_c,
   input  logic [MID_W*NMID-1:0] mid_c,
   input  logic [LAST_W-1:0]     last_c,
   output logic [OUT_W-1:0]      word
);

   localparam int FRONT_SH = NMID + 1;
   localparam int BIAS     = 1 << (OUT_W - 1);
   localparam int TOP      = (1 << OUT_W) - 1;

   int biased;

   always_comb begin
      int acc;
      acc = (int'(fold_first(first_c)) - 3) * (1 << FRONT_SH);
      for (int k = 0; k < NMID; k++) begin
         acc += (int'(fold_mid(mid_c[MID_W*k +: MID_W])) - 1) * (1 << (NMID - k));
      end
      acc   += int'(last_c) - 1;
      biased = acc + BIAS;
   end

   if (SAT_EN) begin : g_clamp
      always_comb begin
         if (biased > TOP)    word = '1;
         else if (biased < 0) word = '0;
         else                 word = OUT_W'(biased);
      end
   end else begin : g_wrap
      always_comb word = OUT_W'(biased);
   end

endmodule

// File: rtl/pipe_code_combiner.sv
module pipe_code_combiner
   import pcc_pkg::*;
#(
   parameter int NMID   = 4,
   parameter bit SAT_EN = 1'b1,
   localparam int NS    = NMID + 2,
   localparam int OUT_W = NMID + 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [2:0]            in_first,
   input  logic [2*NMID-1:0]     in_mid,
   input  logic [1:0]            in_last,
   output logic [2:0]            dac_pos,
   output logic [2:0]            dac_neg,
   output logic                  out_valid,
   output logic [NMID+3:0]       out_word
);

   if (NMID < 1 || NMID > 24) begin : g_bad_nmid
      $error("pipe_code_combiner: NMID must lie in 1..24");
   end

   logic [FIRST_W-1:0]    al_first;
   logic [MID_W*NMID-1:0] al_mid;
   logic [LAST_W-1:0]     al_last;
   logic                  al_valid;
   logic [OUT_W-1:0]      sum_word;

   // lane j is taken j edges after the front code; depth NS-j aligns them
   pcc_delay_line #(.WIDTH(1), .DEPTH(NS)) u_vld_dl (
      .clk(clk), .rst_n(rst_n), .d(in_valid), .q(al_valid));

   pcc_delay_line #(.WIDTH(FIRST_W), .DEPTH(NS)) u_first_dl (
      .clk(clk), .rst_n(rst_n), .d(in_first), .q(al_first));

   for (genvar k = 0; k < NMID; k++) begin : g_mid_lane
      pcc_delay_line #(.WIDTH(MID_W), .DEPTH(NS - 1 - k)) u_mid_dl (
         .clk(clk), .rst_n(rst_n),
         .d(in_mid[MID_W*k +: MID_W]),
         .q(al_mid[MID_W*k +: MID_W]));
   end

   pcc_delay_line #(.WIDTH(LAST_W), .DEPTH(1)) u_last_dl (
      .clk(clk), .rst_n(rst_n), .d(in_last), .q(al_last));

   pcc_code_sum #(.NMID(NMID), .SAT_EN(SAT_EN)) u_sum (
      .first_c(al_first), .mid_c(al_mid), .last_c(al_last), .word(sum_word));

   pcc_dac_split u_dac (
      .clk(clk), .rst_n(rst_n), .code(in_first), .pos(dac_pos), .neg(dac_neg));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= al_valid;
         if (al_valid) out_word <= sum_word;
      end
   end

endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
   parameter int NMID = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [2:0]      in_first,
   input logic [2:0]      dac_pos,
   input logic [2:0]      dac_neg,
   input logic            out_valid,
   input logic [NMID+3:0] out_word
);

   localparam int NS  = NMID + 2;
   localparam int CW  = $clog2(NS + 2) + 2;

   logic          past_ok;
   logic [CW-1:0] inflight;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         past_ok  <= 1'b0;
         inflight <= '0;
      end else begin
         past_ok  <= 1'b1;
         inflight <= inflight + CW'(in_valid) - CW'(out_valid);
      end
   end

   p_dac_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_pos & dac_neg) == 3'b000);

   p_dac_pos_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_pos[0] || dac_pos[1]) && (!dac_pos[1] || dac_pos[2]));

   p_dac_neg_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_neg[2] || dac_neg[1]) && (!dac_neg[1] || dac_neg[0]));

   // R5 and R6: the controls sum to the folded front decision of the previous edge
   p_dac_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (int'($countones(dac_pos)) - int'($countones(dac_neg))
                   == int'(pcc_pkg::fold_first($past(in_first))) - 3));

   p_valid_owed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (inflight != '0));

   p_valid_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= CW'(NS + 1));

   p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !out_valid) |-> $stable(out_word));

endmodule

bind pipe_code_combiner pcc_checker #(.NMID(NMID)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
   .dac_pos(dac_pos), .dac_neg(dac_neg), .out_valid(out_valid), .out_word(out_word));

// File: tb/pipe_code_combiner_test.sv
module pipe_code_combiner_test;

   localparam int NMID   = 4;
   localparam int NS     = NMID + 2;
   localparam int W      = NMID + 4;
   localparam int NC     = 2000;
   localparam int T_CLK  = 10;
   localparam int WD_CYC = 100000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [2:0]        in_first = '0;
   logic [2*NMID-1:0] in_mid = '0;
   logic [1:0]        in_last = '0;
   logic [2:0]        dac_pos, dac_neg;
   logic              out_valid;
   logic [W-1:0]      out_word;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   bit                s_has   [NC];
   logic [2:0]        s_first [NC];
   logic [2*NMID-1:0] s_mid   [NC];
   logic [1:0]        s_last  [NC];
   logic [2:0]        d_first [NC];
   logic [W-1:0]      last_word;

   always #(T_CLK/2) clk = ~clk;

   pipe_code_combiner #(.NMID(NMID)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_mid(in_mid), .in_last(in_last), .dac_pos(dac_pos), .dac_neg(dac_neg),
      .out_valid(out_valid), .out_word(out_word));

   function automatic int exp_word(logic [2:0] f, logic [2*NMID-1:0] m, logic [1:0] l);
      int acc, b;
      b   = (f == 3'd7) ? 6 : int'(f);
      acc = (b - 3) * (1 << (NMID + 1));
      for (int k = 0; k < NMID; k++) begin
         b = int'(m[2*k +: 2]);
         if (b == 3) b = 2;
         acc += (b - 1) * (1 << (NMID - k));
      end
      acc += int'(l) - 1 + (1 << (W - 1));
      if (acc > (1 << W) - 1) acc = (1 << W) - 1;
      if (acc < 0) acc = 0;
      return acc;
   endfunction

   function automatic logic [5:0] exp_dac(logic [2:0] f);
      int d;
      logic [2:0] p, n;
      d = ((f == 3'd7) ? 6 : int'(f)) - 3;
      p[0] = (d == 3);  n[0] = (d <= 1);
      p[1] = (d >= 1);  n[1] = (d <= -1);
      p[2] = (d >= -1); n[2] = (d == -3);
      return {p, n};
   endfunction

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(int c);
      in_valid = s_has[c];
      in_first = s_has[c] ? s_first[c] : 3'($urandom_range(0, 7));
      d_first[c] = in_first;
      for (int k = 0; k < NMID; k++) begin
         int src;
         src = c - (k + 1);
         if (src >= 0 && s_has[src]) in_mid[2*k +: 2] = s_mid[src][2*k +: 2];
         else                        in_mid[2*k +: 2] = 2'($urandom_range(0, 3));
      end
      if (c - (NS - 1) >= 0 && s_has[c - (NS - 1)]) in_last = s_last[c - (NS - 1)];
      else                                           in_last = 2'($urandom_range(0, 3));
   endtask

   initial begin
      void'($urandom(17));
      for (int c = 0; c < NC; c++) begin
         s_has[c] = 1'b0; s_first[c] = '0; s_mid[c] = '0; s_last[c] = '0; d_first[c] = '0;
      end
      // directed burst (R8): top codes, bottom codes, midscale, illegal codes
      s_has[0] = 1; s_first[0] = 3'd6; s_mid[0] = {NMID{2'd2}}; s_last[0] = 2'd3;
      s_has[1] = 1; s_first[1] = 3'd0; s_mid[1] = {NMID{2'd0}}; s_last[1] = 2'd0;
      s_has[2] = 1; s_first[2] = 3'd3; s_mid[2] = {NMID{2'd1}}; s_last[2] = 2'd1;
      s_has[3] = 1; s_first[3] = 3'd7; s_mid[3] = {NMID{2'd3}}; s_last[3] = 2'd3;
      s_has[9] = 1; s_first[9] = 3'd7; s_mid[9] = {NMID{2'd1}}; s_last[9] = 2'd1;
      s_has[20] = 1; s_first[20] = 3'd5; s_mid[20] = {NMID{2'd3}}; s_last[20] = 2'd0;
      for (int c = 30; c < NC - NS - 2; c++) begin
         s_has[c]   = ($urandom_range(0, 9) < 6);
         s_first[c] = 3'($urandom_range(0, 7));
         s_mid[c]   = 2*NMID'($urandom);
         s_last[c]  = 2'($urandom_range(0, 3));
      end
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 out_valid in reset", int'(out_valid), 0);
      check("R1 out_word in reset", int'(out_word), 0);
      check("R1 dac in reset", int'({dac_pos, dac_neg}), 0);
      last_word = '0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_valid after reset", int'(out_valid), 0);
      check("R1 out_word after reset", int'(out_word), 0);
      for (int c = 0; c < NC; c++) begin
         drive(c);
         @(negedge clk);
         check("R6/R5 dac controls", int'({dac_pos, dac_neg}), int'(exp_dac(d_first[c])));
         if (c >= NS && s_has[c - NS]) begin
            int e;
            e = exp_word(s_first[c - NS], s_mid[c - NS], s_last[c - NS]);
            check("R2 out_valid strobe", int'(out_valid), 1);
            if (c - NS == 0)      check("R4 top clamp", int'(out_word), (1 << W) - 1);
            else if (c - NS == 1) check("R3 bottom codes", int'(out_word), 1);
            else if (c - NS == 2) check("R3 midscale", int'(out_word), 1 << (W - 1));
            else if (c - NS == 3) check("R5 illegal codes fold", int'(out_word), (1 << W) - 1);
            else                  check("R3 weighted word", int'(out_word), e);
            last_word = W'(e);
         end else begin
            check("R2 no strobe", int'(out_valid), 0);
            check("R7 word held", int'(out_word), int'(last_word));
         end
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule